// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block carries out the architectural state change a scalar in-order CPU makes when it takes an exception. The pipeline presents a request with a 4-bit cause code, the faulting effective address, the current PC, a flag telling whether the current instruction sits in a branch delay slot, and the current status word. In one clock edge the block records the saved PC, the saved fault address and the saved status. It also produces the new status word and a redirect to the handler vector.

The saved PC depends on the class of the cause, and it is pulled back by one instruction (4 bytes) when the instruction sits in a delay slot. A status bit moves every vector up into high memory. Each taken exception also emits a strobe that tells the pipeline to drop its delay-slot flag. A debug-ignore input, and any cause code with no handler, make the request vanish without a trace.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Synchronous active-high reset clears `saved_pc`, `saved_ea` and `saved_sr` to zero, sets `sr_out` to 0x0000_0001 (supervisor only), and holds `redir_valid` and `dslot_clr` low.
- R2: A request is accepted when `req_valid` is high, `dbg_ignore` is low and `req_cause` is one of 1..12 or 14. After the accepting edge, `redir_valid` is high for exactly that one cycle and `redir_pc` equals `req_cause`×0x100. When bit 14 of `cur_sr` (the high-vector bit) is set, 0xF000_0000 is added.
- R3: On acceptance, `saved_ea` takes `req_ea` and `saved_sr` takes `cur_sr` exactly as presented, before any modification.
- R4: On acceptance, `sr_out` becomes `cur_sr` with bit 0 (supervisor) set and bits 1 (tick enable), 2 (interrupt enable), 5 (data translation), 6 (instruction translation) and 12 (overflow trap enable) cleared. All other bits pass through.
- R5: The reset cause (code 1) leaves `saved_pc` unchanged.
- R6: For instruction page fault (code 4) and instruction TLB miss (code 10), `saved_pc` is `req_ea`, minus 4 when `in_dslot` is high.
- R7: For bus error (2), data page fault (3), alignment (6), illegal instruction (7), data TLB miss (9), range (11) and trap (14), `saved_pc` is `cur_pc`, minus 4 when `in_dslot` is high.
- R8: For system call (code 12), `saved_pc` is `cur_pc`+4, minus 4 when `in_dslot` is high.
- R9: For tick timer (code 5) and external interrupt (code 8), `saved_pc` is `cur_pc`, minus 4 when `in_dslot` is high. The redirect appears in the cycle right after the accepting edge, with no extra delay.
- R10: `dslot_clr` pulses high together with every `redir_valid` and at no other time.
- R11: A request with `dbg_ignore` high, or with cause 0, 13 or 15, changes no output: the saved registers and `sr_out` hold, and no redirect or clear strobe appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_cause | input | 4 | Cause code |
| req_ea | input | 32 | Faulting effective address |
| cur_pc | input | 32 | Current PC |
| in_dslot | input | 1 | Current instruction is in a delay slot |
| cur_sr | input | 32 | Current status word |
| dbg_ignore | input | 1 | Debug unit suppresses this exception |
| saved_pc | output | 32 | Saved exception PC |
| saved_ea | output | 32 | Saved effective address |
| saved_sr | output | 32 | Saved status word |
| sr_out | output | 32 | New status word |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Handler vector |
| dslot_clr | output | 1 | Clear the pipeline's delay-slot flag |

## Verification
All state is held in output registers, so a wrong decode or a wrong class choice shows on `saved_pc` or `redir_pc` in the first cycle after the accepting edge. A missed mask bit shows on `sr_out` in that same cycle. A request that should have been dropped and was not shows as a stray redirect, or as a saved register that changes while idle. The scoreboard compares every output in every cycle against a reference model kept in the bench.

// File: rtl/exc_pkg.sv
package exc_pkg;
    // cause codes; the handler offset is code << 8
    localparam logic [3:0] C_RESET   = 4'd1;
    localparam logic [3:0] C_BUSERR  = 4'd2;
    localparam logic [3:0] C_DPF     = 4'd3;
    localparam logic [3:0] C_IPF     = 4'd4;
    localparam logic [3:0] C_TICK    = 4'd5;
    localparam logic [3:0] C_ALIGN   = 4'd6;
    localparam logic [3:0] C_ILLEGAL = 4'd7;
    localparam logic [3:0] C_EXTINT  = 4'd8;
    localparam logic [3:0] C_DTLB    = 4'd9;
    localparam logic [3:0] C_ITLB    = 4'd10;
    localparam logic [3:0] C_RANGE   = 4'd11;
    localparam logic [3:0] C_SYSCALL = 4'd12;
    localparam logic [3:0] C_TRAP    = 4'd14;

    // status word bit positions
    localparam int SR_SUP   = 0;
    localparam int SR_TICKE = 1;
    localparam int SR_IRQE  = 2;
    localparam int SR_DXLAT = 5;
    localparam int SR_IXLAT = 6;
    localparam int SR_OVFE  = 12;
    localparam int SR_HIVEC = 14;

    // how the saved PC is formed
    typedef enum logic [2:0] {
        PC_NONE,   // no handler: request dropped
        PC_KEEP,   // saved PC untouched
        PC_EA,     // fetch-side fault: the address itself
        PC_CUR,    // current PC
        PC_NEXT    // current PC + 4
    } pc_src_e;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
    import exc_pkg::*;
(
    input  logic [3:0] cause,
    output pc_src_e    src,
    output logic       known
);
    always_comb begin
        unique case (cause)
            C_RESET:                            src = PC_KEEP;
            C_IPF, C_ITLB:                      src = PC_EA;
            C_BUSERR, C_DPF, C_ALIGN, C_ILLEGAL,
            C_DTLB, C_RANGE, C_TRAP:            src = PC_CUR;
            C_TICK, C_EXTINT:                   src = PC_CUR;
            C_SYSCALL:                          src = PC_NEXT;
            default:                            src = PC_NONE;
        endcase
        known = (src != PC_NONE);
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
    parameter int unsigned    XLEN      = 32,
    parameter int unsigned    VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HI_BASE  = 32'hF000_0000
) (
    input  logic [3:0]      cause,
    input  logic            hivec,
    output logic [XLEN-1:0] vector
);
    localparam int unsigned PADW = XLEN - 4 - VEC_SHIFT;

    logic [XLEN-1:0] offset;

    always_comb begin
        offset = {{PADW{1'b0}}, cause, {VEC_SHIFT{1'b0}}};
        vector = offset + (hivec ? HI_BASE : '0);
    end
endmodule

// File: rtl/exc_pc_calc.sv
module exc_pc_calc
    import exc_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned ISIZE = 4
) (
    input  pc_src_e         src,
    input  logic [XLEN-1:0] ea,
    input  logic [XLEN-1:0] pc,
    input  logic            dslot,
    input  logic [XLEN-1:0] old_pc,
    output logic [XLEN-1:0] new_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ISIZE);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] back;

    always_comb begin
        back = dslot ? STEP : '0;
        unique case (src)
            PC_EA:   base = ea;
            PC_CUR:  base = pc;
            PC_NEXT: base = pc + STEP;
            default: base = old_pc;
        endcase
        new_pc = (src == PC_KEEP || src == PC_NONE) ? old_pc : (base - back);
    end
endmodule

// File: rtl/exc_sr_mask.sv
module exc_sr_mask
    import exc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] sr_in,
    output logic [XLEN-1:0] sr_new
);
    localparam logic [XLEN-1:0] CLR = (XLEN'(1) << SR_TICKE) | (XLEN'(1) << SR_IRQE)
                                    | (XLEN'(1) << SR_DXLAT) | (XLEN'(1) << SR_IXLAT)
                                    | (XLEN'(1) << SR_OVFE);
    localparam logic [XLEN-1:0] SET = XLEN'(1) << SR_SUP;

    assign sr_new = (sr_in & ~CLR) | SET;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned     XLEN      = 32,
    parameter int unsigned     VEC_SHIFT = 8,
    parameter int unsigned     ISIZE     = 4,
    parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [3:0]      req_cause,
    input  logic [XLEN-1:0] req_ea,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            in_dslot,
    input  logic [XLEN-1:0] cur_sr,
    input  logic            dbg_ignore,
    output logic [XLEN-1:0] saved_pc,
    output logic [XLEN-1:0] saved_ea,
    output logic [XLEN-1:0] saved_sr,
    output logic [XLEN-1:0] sr_out,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic            dslot_clr
);
    localparam logic [XLEN-1:0] SR_RST = XLEN'(1) << SR_SUP;

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] eear;
        logic [XLEN-1:0] esr;
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] vec;
        logic            redir;
        logic            dclr;
    } state_t;

    state_t st_d, st_q;

    pc_src_e         src_w;
    logic            known_w;
    logic [XLEN-1:0] vec_w;
    logic [XLEN-1:0] epc_w;
    logic [XLEN-1:0] sr_w;
    logic            take_w;

    exc_cause_decode u_dec (
        .cause (req_cause),
        .src   (src_w),
        .known (known_w)
    );

    exc_vector_gen #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .HI_BASE(HI_BASE)) u_vec (
        .cause  (req_cause),
        .hivec  (cur_sr[SR_HIVEC]),
        .vector (vec_w)
    );

    exc_pc_calc #(.XLEN(XLEN), .ISIZE(ISIZE)) u_pc (
        .src    (src_w),
        .ea     (req_ea),
        .pc     (cur_pc),
        .dslot  (in_dslot),
        .old_pc (st_q.epc),
        .new_pc (epc_w)
    );

    exc_sr_mask #(.XLEN(XLEN)) u_sr (
        .sr_in  (cur_sr),
        .sr_new (sr_w)
    );

    assign take_w = req_valid && !dbg_ignore && known_w;

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        st_d.dclr  = 1'b0;
        if (take_w) begin
            st_d.epc   = epc_w;
            st_d.eear  = req_ea;
            st_d.esr   = cur_sr;
            st_d.sr    = sr_w;
            st_d.vec   = vec_w;
            st_d.redir = 1'b1;
            st_d.dclr  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.epc   <= '0;
            st_q.eear  <= '0;
            st_q.esr   <= '0;
            st_q.sr    <= SR_RST;
            st_q.vec   <= '0;
            st_q.redir <= 1'b0;
            st_q.dclr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign saved_pc    = st_q.epc;
    assign saved_ea    = st_q.eear;
    assign saved_sr    = st_q.esr;
    assign sr_out      = st_q.sr;
    assign redir_valid = st_q.redir;
    assign redir_pc    = st_q.vec;
    assign dslot_clr   = st_q.dclr;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [3:0]      req_cause,
    input logic [XLEN-1:0] req_ea,
    input logic [XLEN-1:0] cur_pc,
    input logic            in_dslot,
    input logic [XLEN-1:0] cur_sr,
    input logic            dbg_ignore,
    input logic [XLEN-1:0] saved_pc,
    input logic [XLEN-1:0] saved_ea,
    input logic [XLEN-1:0] saved_sr,
    input logic [XLEN-1:0] sr_out,
    input logic            redir_valid,
    input logic [XLEN-1:0] redir_pc,
    input logic            dslot_clr
);
    logic acc;
    assign acc = req_valid && !dbg_ignore && req_cause != 4'd0
              && req_cause != 4'd13 && req_cause != 4'd15;

    // R2
    accept_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> redir_valid && redir_pc[7:0] == 8'h00);

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> saved_ea == $past(req_ea) && saved_sr == $past(cur_sr));

    // R4
    sr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> sr_out[0] && !sr_out[1] && !sr_out[2] && !sr_out[5]
                && !sr_out[6] && !sr_out[12]);

    // R5
    reset_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_cause == 4'd1) |=> $stable(saved_pc));

    // R9
    irq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && (req_cause == 4'd5 || req_cause == 4'd8))
        |=> saved_pc == $past(cur_pc) - (($past(in_dslot)) ? 32'd4 : 32'd0));

    // R10
    dslot_pair_chk: assert property (@(posedge clk) disable iff (rst)
        dslot_clr == redir_valid);

    // R11
    ignore_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !redir_valid && $stable(saved_pc) && $stable(saved_ea)
                 && $stable(saved_sr) && $stable(sr_out));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cause = '0;
    logic [31:0] req_ea = '0;
    logic [31:0] cur_pc = '0;
    logic        in_dslot = 1'b0;
    logic [31:0] cur_sr = '0;
    logic        dbg_ignore = 1'b0;
    logic [31:0] saved_pc, saved_ea, saved_sr, sr_out, redir_pc;
    logic        redir_valid, dslot_clr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] vec;
        logic [31:0] epc;
        bit          keep;
        logic [31:0] eear;
        logic [31:0] esr;
        logic [31:0] sr;
        string       tag;
    } item_t;

    item_t sb[$];

    logic [31:0] m_epc = '0, m_eear = '0, m_esr = '0, m_sr = 32'h1;

    always #5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: applies one request and predicts its effect
    task automatic fire(input logic [3:0] code, input logic [31:0] ea,
                        input logic [31:0] pc, input bit ds,
                        input logic [31:0] sr, input bit ign, input string tag);
        item_t it;
        logic [31:0] back;
        bit ok;
        @(negedge clk);
        req_valid = 1'b1; req_cause = code; req_ea = ea; cur_pc = pc;
        in_dslot = ds; cur_sr = sr; dbg_ignore = ign;
        ok = !ign && code != 4'd0 && code != 4'd13 && code != 4'd15;
        if (ok) begin
            back = ds ? 32'd4 : 32'd0;
            it.vec  = {20'd0, code, 8'd0} + (sr[14] ? 32'hF000_0000 : 32'd0);
            it.keep = (code == 4'd1);
            case (code)
                4'd4, 4'd10: it.epc = ea - back;
                4'd12:       it.epc = pc + 32'd4 - back;
                default:     it.epc = pc - back;
            endcase
            it.eear = ea;
            it.esr  = sr;
            it.sr   = (sr & ~32'h0000_1066) | 32'h1;
            it.tag  = tag;
            sb.push_back(it);
        end
        @(negedge clk);
        req_valid = 1'b0; dbg_ignore = 1'b0;
    endtask

    // monitor: compares every cycle against the model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (redir_valid) begin
                    if (sb.size() == 0) begin
                        chk("R11", "unexpected redirect", 32'd1, 32'd0);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        if (!it.keep) m_epc = it.epc;
                        m_eear = it.eear; m_esr = it.esr; m_sr = it.sr;
                        chk(it.tag, "redir_pc", redir_pc, it.vec);
                        chk(it.tag, "saved_pc", saved_pc, m_epc);
                        chk("R3", "saved_ea", saved_ea, m_eear);
                        chk("R3", "saved_sr", saved_sr, m_esr);
                        chk("R4", "sr_out", sr_out, m_sr);
                        chk("R10", "dslot_clr", {31'd0, dslot_clr}, 32'd1);
                    end
                end else begin
                    chk("R11", "idle saved_pc", saved_pc, m_epc);
                    chk("R11", "idle saved_ea", saved_ea, m_eear);
                    chk("R11", "idle saved_sr", saved_sr, m_esr);
                    chk("R11", "idle sr_out", sr_out, m_sr);
                    chk("R10", "idle dslot_clr", {31'd0, dslot_clr}, 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state (outputs registered while reset was high)
        chk("R1", "saved_pc", saved_pc, 32'd0);
        chk("R1", "saved_ea", saved_ea, 32'd0);
        chk("R1", "saved_sr", saved_sr, 32'd0);
        chk("R1", "sr_out", sr_out, 32'h1);
        chk("R1", "redir_valid", {31'd0, redir_valid}, 32'd0);

        fire(4'd14, 32'h0000_5000, 32'h0000_1000, 0, 32'h0000_0006, 0, "R7");
        fire(4'd7,  32'h0000_5004, 32'h0000_2008, 1, 32'hFFFF_BFFF, 0, "R7");
        fire(4'd2,  32'h8000_0010, 32'h0000_3000, 0, 32'h0000_1060, 0, "R7");
        fire(4'd12, 32'h0,         32'h0000_4000, 0, 32'h0000_0004, 0, "R8");
        fire(4'd12, 32'h0,         32'h0000_4100, 1, 32'h0000_0004, 0, "R8");
        fire(4'd10, 32'h0001_2344, 32'h0000_0040, 1, 32'h0000_0040, 0, "R6");
        fire(4'd4,  32'h0001_8000, 32'h0000_0040, 0, 32'h0000_0040, 0, "R6");
        fire(4'd5,  32'h0,         32'h0000_6000, 0, 32'h0000_0002, 0, "R9");
        fire(4'd8,  32'h0,         32'h0000_7004, 1, 32'h0000_0006, 0, "R9");
        fire(4'd1,  32'hDEAD_0000, 32'h0000_9999, 0, 32'h0000_0000, 0, "R5");
        fire(4'd11, 32'h0,         32'h0000_A000, 0, 32'h0000_4000, 0, "R2");
        fire(4'd9,  32'h0000_BEE0, 32'h0000_B000, 1, 32'hFFFF_FFFF, 0, "R2");
        // R11 suppressed and unknown causes
        fire(4'd6,  32'h1111_1111, 32'h2222_2222, 0, 32'h0,        1, "R11");
        fire(4'd13, 32'h3333_3333, 32'h4444_4444, 0, 32'h0,        0, "R11");
        fire(4'd0,  32'h5555_5555, 32'h6666_6666, 1, 32'h0,        0, "R11");
        fire(4'd15, 32'h7777_7777, 32'h8888_8888, 0, 32'h4000,     0, "R11");

        // back-to-back requests: two redirects in consecutive cycles (R2)
        @(negedge clk);
        req_valid = 1'b1; req_cause = 4'd3; req_ea = 32'h0000_0100;
        cur_pc = 32'h0000_0C00; in_dslot = 1'b0; cur_sr = 32'h0; dbg_ignore = 1'b0;
        sb.push_back('{32'h0000_0300, 32'h0000_0C00, 1'b0, 32'h0000_0100,
                       32'h0, 32'h1, "R2"});
        @(negedge clk);
        req_cause = 4'd8; cur_pc = 32'h0000_0D00; in_dslot = 1'b0;
        sb.push_back('{32'h0000_0800, 32'h0000_0D00, 1'b0, 32'h0000_0100,
                       32'h0, 32'h1, "R9"});
        @(negedge clk);
        req_valid = 1'b0;

        repeat (4) @(negedge clk);
        chk("R2", "pending redirects", sb.size(), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule